// File: doc/BRIEF.md
# SPI EEPROM Slave Serial Front-End

This block is the slave-side serial port of a byte-organised EEPROM-style device. It oversamples chip select, serial clock, serial input and a hold input with the system clock. It shifts in an opcode byte, two address bytes and any data bytes, and shifts read data or status out on the serial output. It also produces the output-enable that controls the tri-state driver on the pad. Toward the device core it issues single-cycle strobes: write-enable and write-disable commands, a status write, a memory write, and a memory read request. Read data comes back one clock after a read request.

Only clock modes 0 and 3 are served. A frame starts when chip select falls. An opcode the block does not recognise silences the port until chip select is released and lowered again. A hold input can pause a transfer mid-byte without losing the bit position. The pause starts or ends only while the serial clock is low. The array size is set by a parameter, and the address wraps at the end of the array.

Top module: `spi_eeprom_front`

## Requirements
- R1: Serial input is sampled on rising SCK edges and serial output changes on falling SCK edges, most significant bit first. Frames work with SCK idling low (mode 0) and idling high (mode 3).
- R2: The first complete byte after chip select falls is the opcode. Opcode 8'h06 pulses `cmd_wren` and 8'h04 pulses `cmd_wrdi`, each for one clock once that byte completes.
- R3: Opcode 8'h02 is followed by two address bytes, high byte first. Only the low log2(DEPTH) bits are used. Each later data byte pulses `mem_wr` with `mem_wdata` and `mem_addr`, and the address then steps by one, wrapping from DEPTH-1 to 0.
- R4: Opcode 8'h03 is followed by two address bytes, then `mem_rd` pulses. `mem_rdata`, sampled one clock later, is shifted out MSB first. Each finished byte steps the address by one, wrapping to 0, and requests the next byte.
- R5: Opcode 8'h05 shifts out `stat_in` and repeats it for every further byte of the frame.
- R6: Opcode 8'h01 takes the next byte as a status write: one `stat_wr` pulse with that byte on `mem_wdata`. Later bytes in the frame are ignored.
- R7: Any other opcode produces no strobe and no output enable for the rest of the frame. The next frame decodes normally.
- R8: While chip select is high, SCK and SI have no effect and `so_oe` is low. Raising chip select mid-byte discards the partial byte.
- R9: A hold starts when HOLD goes low while SCK is low and ends when HOLD goes high while SCK is low. While held, `so_oe` is low and SCK edges do not advance the transfer. A HOLD pulse that lies wholly within an SCK high phase has no effect.
- R10: After reset all strobes and `so_oe` are low. No two strobes are ever high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data input |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data output value |
| so_oe | output | 1 | Output enable for the serial output driver |
| stat_in | input | 8 | Status byte returned by the status read opcode |
| cmd_wren | output | 1 | Write-enable command strobe |
| cmd_wrdi | output | 1 | Write-disable command strobe |
| stat_wr | output | 1 | Status write strobe, data on mem_wdata |
| mem_addr | output | log2(DEPTH) | Current array address |
| mem_wdata | output | 8 | Write data for array or status |
| mem_wr | output | 1 | Array write strobe |
| mem_rd | output | 1 | Array read request |
| mem_rdata | input | 8 | Array read data, valid one clock after mem_rd |

## Verification
A HOLD change and an SCK rising edge can be seen in the same oversampling clock. The design must count the edge and leave the hold state alone, because a hold may only change while SCK is low. The bench provokes this by pulsing HOLD low and high again inside the SCK high phase of an opcode bit. It then judges the outcome at the ports: the write-enable strobe must still fire exactly once. A second case holds mid-byte during a read, toggles SCK while held, and checks that the byte reassembled after release equals the addressed data.

// File: rtl/spi_eeprom_front.sv
module spi_eeprom_front #(
  parameter int DEPTH = 32768,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_WRDI = 8'h04,
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_WRSR = 8'h01,
  parameter logic [7:0] OP_READ = 8'h03,
  parameter logic [7:0] OP_WRITE = 8'h02,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  input  logic          hold_n,
  output logic          so,
  output logic          so_oe,
  input  logic [7:0]    stat_in,
  output logic          cmd_wren,
  output logic          cmd_wrdi,
  output logic          stat_wr,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_wr,
  output logic          mem_rd,
  input  logic [7:0]    mem_rdata
);

  logic [1:0] s_cs, s_sck, s_si, s_hold;
  logic sck_d, held, lock, tx_on, so_r, rd_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [1:0] idx;
  logic [7:0] op, addr_hi, tx_sr, wdata;
  logic [AW-1:0] addr;

  wire cs_s = s_cs[1];
  wire live = ~cs_s & ~held & ~lock;
  wire rise = live & s_sck[1] & ~sck_d;
  wire fall = live & ~s_sck[1] & sck_d;
  wire [7:0] rx_byte = {rx_sr, s_si[1]};
  wire done = rise & (bit_cnt == 3'd7);

  assign so = so_r;
  assign so_oe = tx_on & ~cs_s & ~held & ~lock;
  assign mem_addr = addr;
  assign mem_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs <= 2'b11; s_sck <= 2'b00; s_si <= 2'b00; s_hold <= 2'b11;
      sck_d <= 1'b0; held <= 1'b0; lock <= 1'b0; tx_on <= 1'b0;
      so_r <= 1'b0; rd_q <= 1'b0; bit_cnt <= '0; rx_sr <= '0; idx <= '0;
      op <= '0; addr_hi <= '0; tx_sr <= '0; wdata <= '0; addr <= '0;
      cmd_wren <= 1'b0; cmd_wrdi <= 1'b0; stat_wr <= 1'b0;
      mem_wr <= 1'b0; mem_rd <= 1'b0;
    end else begin
      s_cs <= {s_cs[0], cs_n};
      s_sck <= {s_sck[0], sck};
      s_si <= {s_si[0], si};
      s_hold <= {s_hold[0], hold_n};
      sck_d <= s_sck[1];
      cmd_wren <= 1'b0; cmd_wrdi <= 1'b0; stat_wr <= 1'b0;
      mem_wr <= 1'b0; mem_rd <= 1'b0;
      rd_q <= mem_rd;
      if (mem_wr) addr <= addr + AW'(1);
      if (rd_q) begin
        tx_sr <= mem_rdata;
        tx_on <= 1'b1;
      end
      if (cs_s) begin
        held <= 1'b0; lock <= 1'b0; tx_on <= 1'b0;
        bit_cnt <= '0; idx <= '0;
      end else begin
        if (!s_sck[1]) held <= ~s_hold[1];
        if (rise) begin
          bit_cnt <= bit_cnt + 3'd1;
          rx_sr <= {rx_sr[5:0], s_si[1]};
        end
        if (fall && tx_on) begin
          so_r <= tx_sr[7];
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
        if (done) begin
          if (idx != 2'd3) idx <= idx + 2'd1;
          case (idx)
            2'd0: begin
              op <= rx_byte;
              if (rx_byte == OP_WREN) cmd_wren <= 1'b1;
              else if (rx_byte == OP_WRDI) cmd_wrdi <= 1'b1;
              else if (rx_byte == OP_RDSR) begin
                tx_sr <= stat_in;
                tx_on <= 1'b1;
              end else if (rx_byte != OP_WRSR && rx_byte != OP_READ && rx_byte != OP_WRITE)
                lock <= 1'b1;
            end
            2'd1: begin
              if (op == OP_WRSR) begin
                wdata <= rx_byte;
                stat_wr <= 1'b1;
              end else addr_hi <= rx_byte;
            end
            2'd2: begin
              if (op == OP_READ || op == OP_WRITE) addr <= AW'({addr_hi, rx_byte});
              if (op == OP_READ) mem_rd <= 1'b1;
            end
            default: begin
              if (op == OP_WRITE) begin
                wdata <= rx_byte;
                mem_wr <= 1'b1;
              end
              if (op == OP_READ) begin
                addr <= addr + AW'(1);
                mem_rd <= 1'b1;
              end
            end
          endcase
          if (idx != 2'd0 && op == OP_RDSR) tx_sr <= stat_in;
        end
      end
    end
  end

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wren, cmd_wrdi, stat_wr, mem_wr, mem_rd}));

  p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (!mem_wr && mem_addr == $past(mem_addr) + AW'(1)));

  p_hold_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && s_sck[1]) |=> $stable(held));

  p_lock_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !cs_s) |=> lock);

  p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !(cmd_wren || cmd_wrdi || stat_wr || mem_wr || mem_rd));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !so_oe);

endmodule

// File: tb/spi_eeprom_front_tb.sv
module spi_eeprom_front_tb;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, cmd_wren, cmd_wrdi, stat_wr, mem_wr, mem_rd;
  logic [7:0] stat_in = 8'hA5, mem_wdata, mem_rdata;
  logic [14:0] mem_addr;

  int checks = 0, fails = 0;
  int n_wren, n_wrdi, n_sw, n_wr, n_rd;
  logic [7:0] last_sw;
  logic oe_seen;
  logic [14:0] wa [8];
  logic [7:0] wd [8];
  logic [7:0] r0, r1, r2;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  assign mem_rdata = pat(mem_addr);

  spi_eeprom_front u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .stat_in(stat_in), .cmd_wren(cmd_wren),
    .cmd_wrdi(cmd_wrdi), .stat_wr(stat_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (cmd_wren) n_wren++;
    if (cmd_wrdi) n_wrdi++;
    if (stat_wr) begin n_sw++; last_sw = mem_wdata; end
    if (mem_wr) begin wa[n_wr & 7] = mem_addr; wd[n_wr & 7] = mem_wdata; n_wr++; end
    if (mem_rd) n_rd++;
    if (so_oe) oe_seen = 1'b1;
  end

  task automatic clr();
    n_wren = 0; n_wrdi = 0; n_sw = 0; n_wr = 0; n_rd = 0; last_sw = 0; oe_seen = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n = H);
    repeat (n) @(negedge clk);
  endtask

  task automatic fstart(input logic m3);
    sck = m3; hw(); cs_n = 1'b0; hw();
  endtask

  task automatic fend(input logic m3);
    if (!m3) begin sck = 1'b0; hw(); end
    cs_n = 1'b1; hw(); hw();
  endtask

  task automatic sbit(input logic b, output logic r);
    sck = 1'b0; si = b; hw(); r = so; sck = 1'b1; hw();
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) sbit(tx[i], rx[i]);
  endtask

  localparam logic [24:0] VEC [6] = '{
    {1'b0, 16'h0000, 8'h11}, {1'b1, 16'h1234, 8'hA5}, {1'b0, 16'hFFFF, 8'h3C},
    {1'b1, 16'h7FFF, 8'h80}, {1'b0, 16'h8001, 8'h7E}, {1'b1, 16'h4000, 8'h01}};

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic m;
    logic [15:0] a;
    logic [7:0] d, junk;
    clr();
    hw(3); rst_n = 1'b1; hw(3);
    chk("R10 reset so_oe", so_oe, 0);
    chk("R10 reset strobes", {cmd_wren, cmd_wrdi, stat_wr, mem_wr, mem_rd}, 0);

    for (int v = 0; v < 6; v++) begin
      {m, a, d} = VEC[v];
      clr();
      fstart(m); xfer(8'h02, junk); xfer(a[15:8], junk); xfer(a[7:0], junk); xfer(d, junk); fend(m);
      chk("R3 write count", n_wr, 1);
      chk("R3 write addr", wa[0], a[14:0]);
      chk("R3 write data", wd[0], d);
      fstart(m); xfer(8'h03, junk); xfer(a[15:8], junk); xfer(a[7:0], junk); xfer(8'h00, r0); fend(m);
      chk("R1 R4 read byte", r0, pat(a[14:0]));
    end

    clr(); fstart(0); xfer(8'h06, junk); fend(0);
    chk("R2 wren strobe", n_wren, 1);
    fstart(1); xfer(8'h04, junk); fend(1);
    chk("R2 wrdi strobe", n_wrdi, 1);

    clr(); fstart(0); xfer(8'h05, junk); xfer(8'h00, r0);
    chk("R5 so_oe during status", so_oe, 1);
    xfer(8'h00, r1); fend(0);
    chk("R5 status byte 1", r0, 8'hA5);
    chk("R5 status byte 2", r1, 8'hA5);
    chk("R8 so_oe after cs high", so_oe, 0);

    clr(); fstart(1); xfer(8'h01, junk); xfer(8'h3C, junk); xfer(8'h77, junk); fend(1);
    chk("R6 status write count", n_sw, 1);
    chk("R6 status write data", last_sw, 8'h3C);

    clr(); fstart(0); xfer(8'h02, junk); xfer(8'h7F, junk); xfer(8'hFF, junk);
    xfer(8'hD1, junk); xfer(8'hD2, junk); xfer(8'hD3, junk); fend(0);
    chk("R3 burst count", n_wr, 3);
    chk("R3 burst addr 0", wa[0], 15'h7FFF);
    chk("R3 burst wrap addr", wa[1], 15'h0000);
    chk("R3 burst addr 2", wa[2], 15'h0001);
    chk("R3 burst data 2", wd[2], 8'hD3);

    clr(); fstart(1); xfer(8'h03, junk); xfer(8'hFF, junk); xfer(8'hFE, junk);
    xfer(8'h00, r0); xfer(8'h00, r1); xfer(8'h00, r2); fend(1);
    chk("R4 read 7FFE", r0, pat(15'h7FFE));
    chk("R4 read 7FFF", r1, pat(15'h7FFF));
    chk("R4 read wrap 0", r2, pat(15'h0000));

    clr(); fstart(0); xfer(8'hFF, junk); xfer(8'h03, junk); xfer(8'h00, junk);
    xfer(8'h00, junk); xfer(8'h06, junk); fend(0);
    chk("R7 no strobes after bad opcode", n_wren + n_wrdi + n_sw + n_wr + n_rd, 0);
    chk("R7 so_oe stays low", oe_seen, 0);
    fstart(0); xfer(8'h06, junk); fend(0);
    chk("R7 next frame decodes", n_wren, 1);

    clr(); hw();
    for (int i = 7; i >= 0; i--) begin
      si = 1'(8'h06 >> i); sck = 1'b1; hw(); sck = 1'b0; hw();
    end
    chk("R8 SI ignored while deselected", n_wren + n_wrdi + n_sw + n_wr + n_rd, 0);
    fstart(0);
    for (int i = 0; i < 5; i++) sbit(1'b0, junk[0]);
    fend(0);
    fstart(0); xfer(8'h06, junk); fend(0);
    chk("R8 partial byte discarded", n_wren, 1);

    clr(); fstart(0); xfer(8'h02, junk); xfer(8'h12, junk);
    sck = 1'b0; hw(); hold_n = 1'b0; hw();
    for (int i = 0; i < 4; i++) begin si = 1'(i); sck = 1'b1; hw(); sck = 1'b0; hw(); end
    hold_n = 1'b1; hw();
    xfer(8'h34, junk); xfer(8'h99, junk); fend(0);
    chk("R9 write addr after hold", wa[0], 15'h1234);
    chk("R9 write data after hold", wd[0], 8'h99);

    clr(); fstart(0); xfer(8'h03, junk); xfer(8'h05, junk); xfer(8'h67, junk);
    for (int i = 7; i >= 5; i--) sbit(1'b0, r0[i]);
    sck = 1'b0; hw(); hold_n = 1'b0; hw();
    chk("R9 so_oe low while held", so_oe, 0);
    for (int i = 0; i < 3; i++) begin sck = 1'b1; hw(); sck = 1'b0; hw(); end
    hold_n = 1'b1; hw();
    for (int i = 4; i >= 0; i--) sbit(1'b0, r0[i]);
    fend(0);
    chk("R9 read byte across hold", r0, pat(15'h0567));

    clr(); fstart(0);
    for (int i = 7; i >= 4; i--) sbit(1'(8'h06 >> i), junk[0]);
    sck = 1'b0; si = 1'b0; hw(); sck = 1'b1; hw(2);
    hold_n = 1'b0; hw(); hold_n = 1'b1; hw();
    for (int i = 2; i >= 0; i--) sbit(1'(8'h06 >> i), junk[0]);
    fend(0);
    chk("R9 hold pulse in high phase ignored", n_wren, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule